// File: doc/BRIEF.md
# EDID block fetcher

This block is a bus initiator on the two-wire display data channel. Give it a block number and a start command, and it fetches one 128-byte block of display identification data into a local buffer. It first writes the segment pointer of the sink, so blocks past the first pair can be reached. It then addresses the data device at the half-block offset that the block number selects, and reads the 128 bytes in one burst. The host reads the result through a random-access buffer port.

The host starts a fetch by raising the command bit and then lowering it. When the bus has been released, a sticky completion flag comes up, and the host clears it. If the sink refuses any address or offset byte, the fetch is cut short: the bus still gets a STOP, and a sticky error flag is raised next to the completion flag. Byte 0x7E of block 0 holds the number of extension blocks. The host reads it from the buffer and decides which blocks to fetch next. Each SCL quarter lasts a programmable number of clock cycles. When the programmed value is zero, the block uses a built-in count that gives 100 kHz from the system clock.

Top module: `edid_block_fetcher`

## Requirements
- R1: Out of reset, both bus lines are released (`scl_oe`=0, `sda_oe`=0) and `busy`, `done` and `err` are 0.
- R2: A fetch is launched only by a high-to-low transition of `go` while idle. Holding `go` high starts nothing, and `go` transitions during a fetch are ignored.
- R3: The bus transaction is, in this order: START, 0x60, block/2, START, 0xA0, offset, START, 0xA1, 128 read bytes, STOP. The offset is 0x80 for an odd block number and 0x00 for an even one.
- R4: The initiator acknowledges (SDA low) each of the first 127 read bytes and does not acknowledge (SDA released) the 128th.
- R5: The k-th byte read (k = 0..127) is stored at buffer index k, and `buf_data` shows the byte at `buf_addr` combinationally.
- R6: `done` rises in the same cycle that `busy` falls. It stays set until a cycle with `flag_clr`=1. If the clear and the set fall in the same cycle, the set wins. `flag_clr` also clears `err`.
- R7: If the sink does not acknowledge any written byte, the block goes straight to STOP with no further bytes, sets `err` together with `done`, and leaves the buffer unchanged.
- R8: While SCL is high during a fetch, SDA changes only within a START or a STOP.
- R9: Each SCL quarter lasts `qtr_div` clock cycles, so every SCL high phase inside a fetch is 2·`qtr_div` cycles long. When `qtr_div`=0, the quarter is CLK_HZ/(4·SCL_HZ) cycles, which is 312 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_sel | input | 8 | Block number, captured at launch |
| go | input | 1 | Command bit; its falling edge launches a fetch |
| flag_clr | input | 1 | Clears `done` and `err` |
| qtr_div | input | 16 | SCL quarter length in cycles; 0 selects the built-in count |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky refusal flag |
| buf_addr | input | 7 | Buffer read index |
| buf_data | output | 8 | Buffer byte at `buf_addr` |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The host clear of the flags and the setting of `done` at the end of a fetch can land in the same cycle. The bench provokes this by holding `flag_clr` high for a whole fetch. It then expects `done` to be visible for exactly one cycle, which shows the set beat the clear; if the clear won, the flag would never appear. A `go` edge that arrives while a fetch is running is also applied. The scoreboard must then see exactly one transaction's worth of bus events, with nothing after the STOP.

// File: rtl/edid_block_fetcher.sv
module edid_block_fetcher #(
  parameter int CLK_HZ = 125_000_000,
  parameter int SCL_HZ = 100_000,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       blk_sel,
  input  logic             go,
  input  logic             flag_clr,
  input  logic [DIV_W-1:0] qtr_div,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic [6:0]       buf_addr,
  output logic [7:0]       buf_data,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam int DEF_QTR = CLK_HZ / (4 * SCL_HZ);
  localparam logic [3:0] S_ST0 = 4'd0, S_SEGA = 4'd1, S_SEGV = 4'd2,
                         S_ST1 = 4'd3, S_DEVW = 4'd4, S_OFFS = 4'd5,
                         S_ST2 = 4'd6, S_DEVR = 4'd7, S_RD   = 4'd8,
                         S_SP  = 4'd9;

  logic             go_q, nak;
  logic [7:0]       blk_q, shr, tx;
  logic [3:0]       seq, bitn;
  logic [1:0]       qph;
  logic [6:0]       idx;
  logic [DIV_W-1:0] cnt;
  logic [7:0]       mem [128];
  logic             scl_lvl, sda_lvl;

  wire launch = go_q & ~go & ~busy;
  wire [DIV_W-1:0] qlen = (qtr_div == '0) ? DIV_W'(DEF_QTR) : qtr_div;
  wire tick = busy & (cnt == qlen - DIV_W'(1));
  wire op_start = (seq == S_ST0) | (seq == S_ST1) | (seq == S_ST2);
  wire op_wr = (seq == S_SEGA) | (seq == S_SEGV) | (seq == S_DEVW) |
               (seq == S_OFFS) | (seq == S_DEVR);
  wire op_rd = (seq == S_RD);
  wire op_stop = (seq == S_SP);
  wire byte_end = tick & (qph == 2'd3) & (op_wr | op_rd) & (bitn == 4'd8);

  always_comb begin
    case (seq)
      S_SEGA:  tx = 8'h60;
      S_SEGV:  tx = {1'b0, blk_q[7:1]};
      S_DEVW:  tx = 8'hA0;
      S_OFFS:  tx = blk_q[0] ? 8'h80 : 8'h00;
      S_DEVR:  tx = 8'hA1;
      default: tx = 8'h00;
    endcase
  end

  always_comb begin
    scl_lvl = 1'b1;
    sda_lvl = 1'b1;
    if (busy) begin
      if (op_start) begin
        scl_lvl = (qph == 2'd1) | (qph == 2'd2);
        sda_lvl = (qph < 2'd2);
      end else if (op_stop) begin
        scl_lvl = (qph != 2'd0);
        sda_lvl = (qph >= 2'd2);
      end else begin
        scl_lvl = (qph == 2'd1) | (qph == 2'd2);
        if (op_wr) sda_lvl = (bitn == 4'd8) ? 1'b1 : tx[3'd7 - bitn[2:0]];
        else       sda_lvl = (bitn == 4'd8) ? (&idx) : 1'b1;
      end
    end
  end

  assign scl_oe = ~scl_lvl;
  assign sda_oe = ~sda_lvl;
  assign buf_data = mem[buf_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= 1'b0; nak <= 1'b0;
      blk_q <= '0; shr <= '0; seq <= S_ST0; bitn <= '0; qph <= '0;
      idx <= '0; cnt <= '0;
    end else begin
      go_q <= go;
      if (flag_clr) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      if (launch) begin
        busy <= 1'b1; blk_q <= blk_sel; seq <= S_ST0; qph <= '0;
        bitn <= '0; idx <= '0; cnt <= '0; nak <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + DIV_W'(1);
        if (tick) begin
          qph <= qph + 2'd1;
          if (qph == 2'd1) begin
            if (op_wr && bitn == 4'd8) nak <= sda_i;
            if (op_rd && bitn < 4'd8) shr <= {shr[6:0], sda_i};
          end
          if (qph == 2'd3) begin
            if (op_start) begin
              seq <= seq + 4'd1;
            end else if (op_stop) begin
              busy <= 1'b0;
              done <= 1'b1;
              if (nak) err <= 1'b1;
            end else if (bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
            end else begin
              bitn <= '0;
              if (op_wr)       seq <= nak ? S_SP : seq + 4'd1;
              else if (&idx)   seq <= S_SP;
              else             idx <= idx + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_end && op_rd) mem[idx] <= shr;
  end

  assert_launch_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(go) && $past(go, 2)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_clr) |=> done);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  assert_sda_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (op_start || op_stop));

endmodule

// File: tb/edid_block_fetcher_bench.sv
`timescale 1ns/1ps
module edid_block_fetcher_bench;
  localparam logic [3:0] T_ST = 4'd1, T_SP = 4'd2, T_WR = 4'd3, T_AK = 4'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] blk_sel = '0;
  logic go = 1'b0, flag_clr = 1'b0;
  logic [15:0] qtr_div = 16'd2;
  logic busy, done, err, scl_oe, sda_oe, sda_i;
  logic [6:0] buf_addr = '0;
  logic [7:0] buf_data;
  logic sl_pull = 1'b0;

  int checks = 0, errors = 0;
  logic [11:0] expq[$];

  always #4 clk = ~clk;

  assign sda_i = ~(sda_oe | sl_pull);

  edid_block_fetcher u_edid_block_fetcher (
    .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .go(go), .flag_clr(flag_clr),
    .qtr_div(qtr_div), .busy(busy), .done(done), .err(err),
    .buf_addr(buf_addr), .buf_data(buf_data), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  function automatic logic [7:0] sink_byte(logic [7:0] s, logic [7:0] a);
    return (s * 8'd29) ^ (a * 8'd7 + 8'h5B);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic observe(logic [3:0] t, logic [7:0] d);
    logic [11:0] e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R2/R3 unexpected bus event: actual %0h expected none", {t, d});
    end else begin
      e = expq.pop_front();
      if (e !== {t, d}) begin
        errors++;
        $display("FAIL %s bus event: actual %0h expected %0h",
                 (t == T_AK) ? "R4" : "R3", {t, d}, e);
      end
    end
  endtask

  // driver side of the scoreboard: expected bus events for one fetch
  task automatic push_fetch(logic [7:0] b, int nack_at);
    logic [7:0] wr[5];
    wr[0] = 8'h60; wr[1] = {1'b0, b[7:1]}; wr[2] = 8'hA0;
    wr[3] = b[0] ? 8'h80 : 8'h00; wr[4] = 8'hA1;
    for (int k = 0; k < 5; k++) begin
      if (k == 0 || k == 2 || k == 4) expq.push_back({T_ST, 8'h00});
      expq.push_back({T_WR, wr[k]});
      if (k == nack_at) begin
        expq.push_back({T_SP, 8'h00});
        return;
      end
    end
    for (int k = 0; k < 128; k++) expq.push_back({T_AK, (k == 127) ? 8'h01 : 8'h00});
    expq.push_back({T_SP, 8'h00});
  endtask

  // sink model and monitor side of the scoreboard
  logic pscl = 1'b1, psda = 1'b1, scl_n, sda_n;
  int mode = 0, bitc = 0, nack_pos = -1, wpos = 0, hrun = 0, hmin = 0, hmax = 0;
  logic first = 1'b0, drv = 1'b0, acked = 1'b0, was_addr = 1'b0, macked = 1'b0;
  logic [7:0] shf = '0, addr_b = '0, seg_r = '0, ptr = '0, txb = '0;

  always @(negedge clk) begin
    scl_n = ~scl_oe;
    sda_n = ~(sda_oe | sl_pull);
    if (!busy) hrun = 0;
    else if (pscl && !scl_n) begin
      if (hrun > 0) begin
        if (hmin == 0 || hrun < hmin) hmin = hrun;
        if (hrun > hmax) hmax = hrun;
      end
      hrun = 0;
    end else if (scl_n) hrun++;
    if (pscl && scl_n && psda && !sda_n) begin
      observe(T_ST, 8'h00);
      mode = 1; bitc = 0; first = 1'b1; drv = 1'b0; sl_pull = 1'b0;
    end else if (pscl && scl_n && !psda && sda_n) begin
      observe(T_SP, 8'h00);
      mode = 0; sl_pull = 1'b0;
    end else if (!pscl && scl_n) begin
      if (mode == 1) begin
        if (bitc < 8) shf = {shf[6:0], sda_n};
        if (bitc < 9) bitc++;
      end else if (mode == 2) begin
        if (bitc == 8) begin
          observe(T_AK, {7'd0, sda_n});
          macked = ~sda_n;
        end
        bitc++;
      end
    end else if (pscl && !scl_n) begin
      if (mode == 1) begin
        if (bitc == 8 && !drv) begin
          observe(T_WR, shf);
          acked = (wpos != nack_pos);
          wpos++;
          sl_pull = acked;
          drv = 1'b1;
          was_addr = first;
          if (first) begin
            addr_b = shf; first = 1'b0;
          end else if (addr_b == 8'h60) seg_r = shf;
          else if (addr_b == 8'hA0) ptr = shf;
        end else if (bitc == 9) begin
          sl_pull = 1'b0; drv = 1'b0; bitc = 0;
          if (was_addr && acked && addr_b == 8'hA1) begin
            mode = 2;
            txb = sink_byte(seg_r, ptr);
            sl_pull = ~txb[7];
          end
        end
      end else if (mode == 2) begin
        if (bitc >= 1 && bitc <= 7) sl_pull = ~txb[7-bitc];
        else if (bitc == 8) sl_pull = 1'b0;
        else if (bitc == 9) begin
          bitc = 0;
          if (macked) begin
            ptr = ptr + 8'd1;
            txb = sink_byte(seg_r, ptr);
            sl_pull = ~txb[7];
          end else begin
            mode = 0; sl_pull = 1'b0;
          end
        end
      end
    end
    pscl = scl_n;
    psda = sda_n;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pulse_go();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic wait_fetch();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic chk_buf(logic [7:0] s, logic [7:0] base, string req);
    for (int i = 0; i < 128; i++) begin
      buf_addr = 7'(i);
      #1;
      check(req, buf_data, sink_byte(s, base + 8'(i)));
    end
  endtask

  task automatic prep(logic [7:0] b, int nk, logic [15:0] q);
    blk_sel = b; nack_pos = nk; wpos = 0; qtr_div = q; hmin = 0; hmax = 0;
    push_fetch(b, nk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);

    // R2 holding go high starts nothing; falling edge starts block 0
    @(negedge clk) go = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 held go no launch", busy, 0);
    prep(8'd0, -1, 16'd2);
    go = 1'b0;
    wait_fetch();
    check("R6 done after fetch", done, 1);
    check("R7 no err", err, 0);
    check("R3 all events seen", expq.size(), 0);
    check("R9 scl high min", hmin, 4);
    check("R9 scl high max", hmax, 4);
    chk_buf(8'd0, 8'h00, "R5 block 0");

    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R6 clear done", done, 0);

    // odd block, go pulse during fetch is ignored
    prep(8'd3, -1, 16'd3);
    pulse_go();
    repeat (300) @(negedge clk);
    pulse_go();
    wait_fetch();
    repeat (300) @(negedge clk);
    check("R2 no second fetch", busy, 0);
    check("R2 queue empty", expq.size(), 0);
    check("R6 done sticky", done, 1);
    check("R9 scl high q3", hmax, 6);
    chk_buf(8'd1, 8'h80, "R5 block 3");

    // clear held across completion: set must win for one cycle
    prep(8'd254, -1, 16'd2);
    @(negedge clk) flag_clr = 1'b1;
    pulse_go();
    hi = 0;
    wait_fetch();
    if (done) hi++;
    repeat (5) begin
      @(negedge clk);
      if (done) hi++;
    end
    flag_clr = 1'b0;
    check("R6 set beats clear", hi, 1);
    check("R3 block 254 events", expq.size(), 0);
    chk_buf(8'd127, 8'h00, "R5 block 254");

    // refusal of the offset byte
    prep(8'd5, 3, 16'd2);
    pulse_go();
    wait_fetch();
    check("R7 err set", err, 1);
    check("R7 done set", done, 1);
    check("R7 events", expq.size(), 0);
    chk_buf(8'd127, 8'h00, "R7 buffer unchanged");
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R6 clear err", err, 0);
    check("R6 clear done", done, 0);

    // built-in divider, refusal of the segment pointer address
    prep(8'd9, 0, 16'd0);
    pulse_go();
    wait_fetch();
    check("R7 early abort err", err, 1);
    check("R7 early abort events", expq.size(), 0);
    check("R9 default scl high", hmax, 624);
    check("R9 default scl high min", hmin, 624);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule